// File: doc/BRIEF.md
# Splittable Three-Input Logic and Arithmetic Unit

This block is the single-cycle data-unit ALU of a pixel-processing datapath. It takes three 32-bit operands. In logic mode an 8-bit truth-table code selects any of the 256 Boolean functions of three inputs, and the function is applied to every bit position. In arithmetic mode it adds or subtracts the first two operands and can shift the sum right logically in the same operation. The word can be split into independent byte or halfword lanes. No carry crosses a lane boundary, and each lane has its own set of status flags.

Two conditional controls wrap the datapath. A condition code tested against the stored lane-0 flags decides whether the operation takes effect at all. A status bit can pick the second operand from one of two sources. When the discard control is set, the flags update but the destination does not, so a subtract can serve as a compare. The destination and the flags are registered. Results appear one clock after the operation is issued.

Top module: `tri_alu`

## Requirements
- R1: In logic mode (`arith_i`=0), result bit i equals `truth_i[{A[i],B[i],C[i]}]`, with A as the most significant index bit.
- R2: In arithmetic mode, `arith_op_i` selects the operation: 00 computes A+B, 01 computes A-B, 10 computes (A+B)>>s and 11 computes (A-B)>>s. The shift is logical and applies within each lane.
- R3: `split_i` selects the lane size: 00 gives four byte lanes, 01 gives two halfword lanes, and 10 or 11 gives one word. Lane k occupies bits [k*W +: W], and no carry propagates from one lane into the next.
- R4: The shift amount uses the low 3 bits of `shamt_i` for byte lanes, the low 4 bits for halfword lanes and all 5 bits for the word.
- R5: When `nsel_en_i`=1, B is `src_b_i` if `nbit_i`=1 and `src_b_alt_i` if `nbit_i`=0. When `nsel_en_i`=0, B is always `src_b_i`.
- R6: `cond_i` is tested against the stored lane-0 flags. The codes are 0 always, 1 Z, 2 not Z, 3 N!=V, 4 N==V, 5 C, 6 not C and 7 never. When the condition fails, the result and all flags stay unchanged.
- R7: With `discard_i`=1, an operation that passes its condition updates the flags but leaves `result_o` unchanged.
- R8: Flag bit k belongs to lane k, and the flag bits of lanes that do not exist are 0. N is the top bit of the final lane result and Z is set when that lane result is zero. C is the carry out of the lane's add, which means no borrow on a subtract. V is the signed overflow of the add or subtract. C and V are taken before the shift.
- R9: In logic mode, C and V are 0 for every lane.
- R10: Reset clears the result and all flags. When `valid_i`=0 the result and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Issue an operation this cycle |
| arith_i | input | 1 | 1 selects arithmetic, 0 selects truth-table logic |
| arith_op_i | input | 2 | Arithmetic operation (add/sub, with or without shift) |
| truth_i | input | 8 | Three-input truth-table code |
| shamt_i | input | 5 | Right-shift amount |
| split_i | input | 2 | Lane size select |
| cond_i | input | 3 | Write-back condition code |
| discard_i | input | 1 | Drop the result and keep the flags |
| nsel_en_i | input | 1 | Enable status-bit source choice for B |
| nbit_i | input | 1 | Status bit that steers the B choice |
| src_a_i | input | 32 | Operand A |
| src_b_i | input | 32 | Operand B, primary source |
| src_b_alt_i | input | 32 | Operand B, alternate source |
| src_c_i | input | 32 | Operand C (logic mode) |
| result_o | output | 32 | Destination register |
| nflag_o | output | 4 | Negative flag per lane |
| cflag_o | output | 4 | Carry flag per lane |
| vflag_o | output | 4 | Overflow flag per lane |
| zflag_o | output | 4 | Zero flag per lane |

## Verification
The assertions assume that reset is held across at least one rising edge before any operation, and that the control inputs are at known 0/1 values whenever `valid_i` is high. They also treat the split code 11 as a second encoding of word mode. The stimulus changes every input only on falling edges and always drives defined values. It draws the split code over all four encodings and the condition code over all eight values, so the hold paths for a failed condition, a discarded result and an idle cycle are reached repeatedly from many different stored flag states.

// File: rtl/tri_alu_pkg.sv
package tri_alu_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SPLIT_BYTE = 2'd0,
    SPLIT_HALF = 2'd1,
    SPLIT_WORD = 2'd2,
    SPLIT_WORD_ALT = 2'd3
  } split_e;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_ZSET   = 3'd1,
    CC_ZCLR   = 3'd2,
    CC_LESS   = 3'd3,
    CC_GEQ    = 3'd4,
    CC_CSET   = 3'd5,
    CC_CCLR   = 3'd6,
    CC_NEVER  = 3'd7
  } cond_e;

  typedef struct packed {
    logic n;
    logic c;
    logic v;
    logic z;
  } flag_t;

  function automatic logic cond_met(input logic [2:0] cc, input flag_t f);
    logic ok;
    case (cond_e'(cc))
      CC_ALWAYS: ok = 1'b1;
      CC_ZSET:   ok = f.z;
      CC_ZCLR:   ok = ~f.z;
      CC_LESS:   ok = f.n ^ f.v;
      CC_GEQ:    ok = ~(f.n ^ f.v);
      CC_CSET:   ok = f.c;
      CC_CCLR:   ok = ~f.c;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic lane_starts(input logic [1:0] split, input int byte_idx);
    logic s;
    case (split_e'(split))
      SPLIT_BYTE: s = 1'b1;
      SPLIT_HALF: s = (byte_idx % 2) == 0;
      default:    s = (byte_idx == 0);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tri_tt_logic.sv
module tri_tt_logic #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] c,
  input  logic [7:0]    code,
  output logic [DW-1:0] y
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign y[i] = code[{a[i], b[i], c[i]}];
  end
endmodule

// File: rtl/tri_lane_adder.sv
module tri_lane_adder
  import tri_alu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB = DW / BYTE_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  input  logic [1:0]    split,
  output logic [DW-1:0] sum,
  output logic [NB-1:0] cout,
  output logic [NB-1:0] ovf
);
  logic [DW-1:0] bx;
  logic [NB-1:0] cin;

  assign bx = sub ? ~b : b;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BYTE_W:0] part;
    logic [BYTE_W-1:0] ab, bb;
    assign ab = a[k*BYTE_W +: BYTE_W];
    assign bb = bx[k*BYTE_W +: BYTE_W];
    if (k == 0) begin : g_first
      assign cin[k] = sub;
    end else begin : g_rest
      assign cin[k] = lane_starts(split, k) ? sub : cout[k-1];
    end
    assign part = {1'b0, ab} + {1'b0, bb} + {{BYTE_W{1'b0}}, cin[k]};
    assign sum[k*BYTE_W +: BYTE_W] = part[BYTE_W-1:0];
    assign cout[k] = part[BYTE_W];
    assign ovf[k] = (ab[BYTE_W-1] == bb[BYTE_W-1]) && (part[BYTE_W-1] != ab[BYTE_W-1]);
  end
endmodule

// File: rtl/tri_lane_post.sv
module tri_lane_post
  import tri_alu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB  = DW / BYTE_W,
  localparam int HW  = 2 * BYTE_W,
  localparam int SHW = $clog2(DW),
  localparam int BSH = $clog2(BYTE_W),
  localparam int HSH = $clog2(HW)
) (
  input  logic [DW-1:0]  value,
  input  logic [1:0]     split,
  input  logic           arith,
  input  logic           do_shift,
  input  logic [SHW-1:0] shamt,
  input  logic [NB-1:0]  cout,
  input  logic [NB-1:0]  ovf,
  output logic [DW-1:0]  res,
  output logic [NB-1:0]  n_o,
  output logic [NB-1:0]  c_o,
  output logic [NB-1:0]  v_o,
  output logic [NB-1:0]  z_o
);
  logic [DW-1:0] shifted;

  always_comb begin
    shifted = value;
    case (split_e'(split))
      SPLIT_BYTE:
        for (int k = 0; k < NB; k++)
          shifted[k*BYTE_W +: BYTE_W] = value[k*BYTE_W +: BYTE_W] >> shamt[BSH-1:0];
      SPLIT_HALF:
        for (int k = 0; k < NB/2; k++)
          shifted[k*HW +: HW] = value[k*HW +: HW] >> shamt[HSH-1:0];
      default:
        shifted = value >> shamt;
    endcase
    res = (arith && do_shift) ? shifted : value;
  end

  always_comb begin
    n_o = '0;
    c_o = '0;
    v_o = '0;
    z_o = '0;
    case (split_e'(split))
      SPLIT_BYTE:
        for (int k = 0; k < NB; k++) begin
          n_o[k] = res[k*BYTE_W + BYTE_W - 1];
          z_o[k] = res[k*BYTE_W +: BYTE_W] == '0;
          c_o[k] = arith & cout[k];
          v_o[k] = arith & ovf[k];
        end
      SPLIT_HALF:
        for (int k = 0; k < NB/2; k++) begin
          n_o[k] = res[k*HW + HW - 1];
          z_o[k] = res[k*HW +: HW] == '0;
          c_o[k] = arith & cout[2*k+1];
          v_o[k] = arith & ovf[2*k+1];
        end
      default: begin
        n_o[0] = res[DW-1];
        z_o[0] = res == '0;
        c_o[0] = arith & cout[NB-1];
        v_o[0] = arith & ovf[NB-1];
      end
    endcase
  end
endmodule

// File: rtl/tri_alu.sv
module tri_alu
  import tri_alu_pkg::*;
#(
  parameter int DW = 32,
  localparam int NB  = DW / BYTE_W,
  localparam int SHW = $clog2(DW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic           arith_i,
  input  logic [1:0]     arith_op_i,
  input  logic [7:0]     truth_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [1:0]     split_i,
  input  logic [2:0]     cond_i,
  input  logic           discard_i,
  input  logic           nsel_en_i,
  input  logic           nbit_i,
  input  logic [DW-1:0]  src_a_i,
  input  logic [DW-1:0]  src_b_i,
  input  logic [DW-1:0]  src_b_alt_i,
  input  logic [DW-1:0]  src_c_i,
  output logic [DW-1:0]  result_o,
  output logic [NB-1:0]  nflag_o,
  output logic [NB-1:0]  cflag_o,
  output logic [NB-1:0]  vflag_o,
  output logic [NB-1:0]  zflag_o
);
  logic [DW-1:0] opnd_b;
  logic [DW-1:0] logic_y;
  logic [DW-1:0] add_y;
  logic [DW-1:0] pre_y;
  logic [DW-1:0] final_y;
  logic [NB-1:0] lane_cout, lane_ovf;
  logic [NB-1:0] n_d, c_d, v_d, z_d;
  flag_t         lane0_q;
  logic          wr_pass;
  logic          wr_result;

  assign opnd_b = (nsel_en_i && !nbit_i) ? src_b_alt_i : src_b_i;

  tri_tt_logic #(.DW(DW)) u_tt (
    .a(src_a_i), .b(opnd_b), .c(src_c_i), .code(truth_i), .y(logic_y)
  );

  tri_lane_adder #(.DW(DW)) u_add (
    .a(src_a_i), .b(opnd_b), .sub(arith_op_i[0]), .split(split_i),
    .sum(add_y), .cout(lane_cout), .ovf(lane_ovf)
  );

  assign pre_y = arith_i ? add_y : logic_y;

  tri_lane_post #(.DW(DW)) u_post (
    .value(pre_y), .split(split_i), .arith(arith_i), .do_shift(arith_op_i[1]),
    .shamt(shamt_i), .cout(lane_cout), .ovf(lane_ovf), .res(final_y),
    .n_o(n_d), .c_o(c_d), .v_o(v_d), .z_o(z_d)
  );

  assign lane0_q   = '{n: nflag_o[0], c: cflag_o[0], v: vflag_o[0], z: zflag_o[0]};
  assign wr_pass   = valid_i && cond_met(cond_i, lane0_q);
  assign wr_result = wr_pass && !discard_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      nflag_o  <= '0;
      cflag_o  <= '0;
      vflag_o  <= '0;
      zflag_o  <= '0;
    end else begin
      if (wr_result) result_o <= final_y;
      if (wr_pass) begin
        nflag_o <= n_d;
        cflag_o <= c_d;
        vflag_o <= v_d;
        zflag_o <= z_d;
      end
    end
  end
endmodule

// File: rtl/tri_alu_chk.sv
module tri_alu_chk #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic          arith_i,
  input logic [1:0]    split_i,
  input logic          discard_i,
  input logic          wr_pass,
  input logic [DW-1:0] result_o,
  input logic [NB-1:0] nflag_o,
  input logic [NB-1:0] cflag_o,
  input logic [NB-1:0] vflag_o,
  input logic [NB-1:0] zflag_o
);
  AST_COND_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !wr_pass |=> $stable(result_o) && $stable(nflag_o) && $stable(zflag_o) && $stable(cflag_o)); // R6
  AST_DISCARD_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && discard_i |=> $stable(result_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o) && $stable(vflag_o) && $stable(cflag_o)); // R10
  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && !arith_i |=> cflag_o == '0 && vflag_o == '0); // R9
  AST_WORD_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && split_i[1] |=> nflag_o[NB-1:1] == '0 && zflag_o[NB-1:1] == '0); // R8
  AST_WORD_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && !discard_i && split_i[1] |=> zflag_o[0] == (result_o == '0)); // R8
  AST_BYTE_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass && !discard_i && split_i == 2'b00 |=> zflag_o[0] == (result_o[7:0] == 8'h00)); // R3
endmodule

bind tri_alu tri_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .arith_i(arith_i),
  .split_i(split_i), .discard_i(discard_i), .wr_pass(wr_pass),
  .result_o(result_o), .nflag_o(nflag_o), .cflag_o(cflag_o),
  .vflag_o(vflag_o), .zflag_o(zflag_o)
);

// File: tb/tri_alu_test.sv
`timescale 1ns/1ps
module tri_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, arith_i = 1'b0, discard_i = 1'b0, nsel_en_i = 1'b0, nbit_i = 1'b0;
  logic [1:0] arith_op_i = '0, split_i = '0;
  logic [7:0] truth_i = '0;
  logic [4:0] shamt_i = '0;
  logic [2:0] cond_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0, src_b_alt_i = '0, src_c_i = '0;
  logic [31:0] result_o;
  logic [3:0] nflag_o, cflag_o, vflag_o, zflag_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_res = '0;
  logic [3:0] exp_n = '0, exp_c = '0, exp_v = '0, exp_z = '0;

  always #2.5 clk = ~clk;

  tri_alu uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic bit cc_ok(logic [2:0] cc, bit n, bit c, bit v, bit z);
    case (cc)
      3'd0: return 1;
      3'd1: return z;
      3'd2: return !z;
      3'd3: return n != v;
      3'd4: return n == v;
      3'd5: return c;
      3'd6: return !c;
      default: return 0;
    endcase
  endfunction

  // Reference: lane loop with wide integers
  task automatic model(output logic [31:0] r, output logic [3:0] fn, output logic [3:0] fc,
                       output logic [3:0] fv, output logic [3:0] fz);
    int nl, w, bi;
    longint unsigned mask, av, bv, full, s, bsel, cin;
    logic [31:0] lg;
    bsel = (nsel_en_i && !nbit_i) ? src_b_alt_i : src_b_i;
    for (int i = 0; i < 32; i++) begin
      bi = 0;
      if (src_a_i[i]) bi += 4;
      if (bsel[i]) bi += 2;
      if (src_c_i[i]) bi += 1;
      lg[i] = truth_i[bi];
    end
    nl = (split_i == 2'd0) ? 4 : (split_i == 2'd1) ? 2 : 1;
    w = 32 / nl;
    mask = (64'd1 << w) - 1;
    r = '0; fn = '0; fc = '0; fv = '0; fz = '0;
    for (int l = 0; l < nl; l++) begin
      if (arith_i) begin
        av = (longint'(src_a_i) >> (l*w)) & mask;
        bv = (bsel >> (l*w)) & mask;
        cin = 0;
        if (arith_op_i[0]) begin bv = (~bv) & mask; cin = 1; end
        full = av + bv + cin;
        s = full & mask;
        fc[l] = full[w];
        fv[l] = (av[w-1] == bv[w-1]) && (s[w-1] != av[w-1]);
        if (arith_op_i[1]) s = s >> (shamt_i % w);
      end else begin
        s = (longint'(lg) >> (l*w)) & mask;
      end
      r = r | 32'(s << (l*w));
      fn[l] = s[w-1];
      fz[l] = (s == 0);
    end
  endtask

  task automatic issue(string tag);
    logic [31:0] r;
    logic [3:0] fn, fc, fv, fz;
    model(r, fn, fc, fv, fz);
    if (cc_ok(cond_i, exp_n[0], exp_c[0], exp_v[0], exp_z[0])) begin
      exp_n = fn; exp_c = fc; exp_v = fv; exp_z = fz;
      if (!discard_i) exp_res = r;
    end
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(tag, result_o, exp_res);
    check(tag, {16'h0, nflag_o, cflag_o, vflag_o, zflag_o}, {16'h0, exp_n, exp_c, exp_v, exp_z});
  endtask

  task automatic setop(bit ar, logic [1:0] op, logic [7:0] tt, logic [1:0] sp,
                       logic [31:0] a, logic [31:0] b, logic [31:0] c);
    arith_i = ar; arith_op_i = op; truth_i = tt; split_i = sp;
    src_a_i = a; src_b_i = b; src_c_i = c;
    cond_i = 3'd0; discard_i = 0; nsel_en_i = 0; shamt_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset result", result_o, 32'h0);
    check("R10 reset flags", {nflag_o, cflag_o, vflag_o, zflag_o}, 32'h0);

    setop(0, 2'd0, 8'hE8, 2'd2, 32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hAAAA_AAAA);
    issue("R1 majority");
    truth_i = 8'h96; issue("R1 xor3");
    truth_i = 8'h00; split_i = 2'd0; issue("R9 logic zero byte flags");

    setop(1, 2'd0, 8'h0, 2'd0, 32'h00FF_00FF, 32'h0001_0001, 0);
    issue("R3 byte carry blocked");
    split_i = 2'd2; issue("R3 word carry flows");
    split_i = 2'd1; src_a_i = 32'h7FFF_FFFF; issue("R8 half flags");

    setop(1, 2'd1, 8'h0, 2'd2, 32'd5, 32'd7, 0);
    issue("R2 word sub");
    setop(1, 2'd3, 8'h0, 2'd0, 32'h8040_2010, 32'h0000_0000, 0);
    shamt_i = 5'd9; issue("R4 byte shift uses low bits");
    split_i = 2'd1; issue("R4 half shift");
    arith_op_i = 2'd2; split_i = 2'd3; issue("R2 word add shift");

    setop(1, 2'd0, 8'h0, 2'd2, 32'd1, 32'd100, 0);
    src_b_alt_i = 32'd200; nsel_en_i = 1; nbit_i = 1; issue("R5 nbit one");
    nsel_en_i = 1; nbit_i = 0; issue("R5 nbit zero");

    setop(1, 2'd1, 8'h0, 2'd2, 32'd3, 32'd5, 0);
    discard_i = 1; issue("R7 compare discards");
    setop(1, 2'd0, 8'h0, 2'd2, 32'd40, 32'd2, 0);
    cond_i = 3'd3; issue("R6 lt passes");
    cond_i = 3'd1; src_a_i = 32'd9; issue("R6 eq fails");
    cond_i = 3'd7; issue("R6 never");

    @(negedge clk);
    check("R10 idle result", result_o, exp_res);
    check("R10 idle flags", {nflag_o, cflag_o, vflag_o, zflag_o}, {16'h0, exp_n, exp_c, exp_v, exp_z});

    for (int t = 0; t < 3000; t++) begin
      arith_i = $urandom_range(0, 1);
      arith_op_i = 2'($urandom);
      truth_i = 8'($urandom);
      shamt_i = 5'($urandom);
      split_i = 2'($urandom);
      cond_i = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0;
      discard_i = ($urandom_range(0, 7) == 0);
      nsel_en_i = $urandom_range(0, 1);
      nbit_i = $urandom_range(0, 1);
      src_a_i = ($urandom_range(0, 9) == 0) ? 32'hFFFF_FFFF : $urandom;
      src_b_i = ($urandom_range(0, 9) == 0) ? 32'h0 : $urandom;
      src_b_alt_i = $urandom;
      src_c_i = $urandom;
      if ($urandom_range(0, 5) == 0) begin
        @(negedge clk);
        check("R10 random idle", result_o, exp_res);
      end
      issue(arith_i ? "R2 random arith" : "R1 random logic");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule